// File: doc/BRIEF.md
# Group-Delay-Aligned Decimating FIR Filter

This block low-pass filters a stream of signed samples and keeps one filtered value in ten. It works on frames. Each frame is a bounded run of samples that starts with a start flag and ends with an end flag. A symmetric odd-length filter delays its input by half its order. To keep each kept output centred on the input instant it belongs to, the block ties its decimation phase to that delay. The block discards the start-up results and keeps the first result after them. It then keeps every tenth result from that point.

At the end of a frame the block feeds the filter copies of the frame's last sample, one per cycle, for as many cycles as the group delay. During that time it holds its ready output low, and nothing new enters. The frame therefore produces the complete set of aligned outputs. The last of these outputs carries an end flag. A fixed coefficient array is given as a parameter. The block computes only the results it keeps. Each kept result is a multiply-accumulate spread over the gap before the next one, so several taps are handled per cycle.

Top module: `dcfd_decimator`

## Requirements
- R1: While reset is active and in the first cycle after it, out_valid and out_eof are 0 and in_ready is 1.
- R2: A frame of N accepted samples produces exactly ceil(N/10) outputs. Two outputs are always at least 10 cycles apart.
- R3: Output j of a frame equals the filtered value y[15+10j], where y[n] = sum over k=0..30 of h[k]·x[n−k]. Here x[0] is the start-of-frame sample and h[k] is entry k of the coefficient array, with entry 0 applied to the newest sample. The filtered values y[0]..y[14] are never output.
- R4: For positions n ≥ N the filter sees x[n] = x[N−1]. This is the last sample of the frame, repeated.
- R5: Start of frame clears history: x[m] = 0 for every m < 0. No sample from an earlier frame affects any output.
- R6: The output is y/2^15 rounded to the nearest integer. Exact halves round away from zero, so +0.5 gives 1 and −0.5 gives −1.
- R7: A rounded result above 32767 is output as 32767. A rounded result below −32768 is output as −32768.
- R8: out_valid is high for one cycle per output. out_eof is high only together with out_valid, and only on the last output of a frame.
- R9: After the block accepts a sample with in_eof set, in_ready is low for exactly 15 cycles. Any in_valid, in_sof, in_eof or in_data presented in those cycles has no effect on the outputs.
- R10: While in_ready is high, a sample is accepted in every cycle with in_valid high. in_ready stays high between the start and end samples of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | Sample is the first of a frame |
| in_eof | input | 1 | Sample is the last of a frame |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Block accepts a sample this cycle |
| out_valid | output | 1 | Output sample present, one-cycle pulse |
| out_eof | output | 1 | Output is the last of its frame |
| out_data | output | 16 | Signed, rounded and saturated output |

## Verification
The checker assumes that every frame opens with a sample flagged start of frame. It also assumes a sample is counted only when in_valid and in_ready are both high, and that a frame never begins before the previous frame's tail has finished. Within those limits, the bench may raise in_valid with junk data and flags while in_ready is low. This tests that the junk has no effect. The bench always waits for in_ready before presenting a real sample. It opens each frame with the start flag and closes it with the end flag. Random idle gaps and random frame lengths from 1 to 120 cover the different phases at which the tail can fall.

// File: rtl/dcfd_pkg.sv
package dcfd_pkg;

  localparam int DCFD_TAPS = 31;

  // Symmetric low-pass taps in Q15, DC gain 1.0 (sum 32768)
  localparam logic signed [15:0] DCFD_COEF [DCFD_TAPS] = '{
    -16'sd45, -16'sd60, -16'sd72, -16'sd65, -16'sd12,
     16'sd110, 16'sd316, 16'sd602, 16'sd964, 16'sd1372,
     16'sd1788, 16'sd2172, 16'sd2481, 16'sd2683, 16'sd2755,
     16'sd2790,
     16'sd2755, 16'sd2683, 16'sd2481, 16'sd2172, 16'sd1788,
     16'sd1372, 16'sd964, 16'sd602, 16'sd316, 16'sd110,
    -16'sd12, -16'sd65, -16'sd72, -16'sd60, -16'sd45
  };

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/dcfd_seq.sv
module dcfd_seq #(
  parameter int DW    = 16,
  parameter int DECIM = 10,
  parameter int DELAY = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic signed [DW-1:0] in_data,
  output logic                 in_ready,
  output logic                 step_en,
  output logic                 step_clr,
  output logic signed [DW-1:0] step_data,
  output logic                 keep,
  output logic                 keep_last
);
  localparam int TW = $clog2(DELAY + 1);
  localparam int PW = (DECIM > 2) ? $clog2(DECIM) : 1;

  logic                 flushing;
  logic [TW-1:0]        pad_cnt;
  logic [TW-1:0]        t_cnt;
  logic [TW-1:0]        cur_t;
  logic [PW-1:0]        ph;
  logic [PW-1:0]        cur_ph;
  logic signed [DW-1:0] last_q;
  logic                 accept;

  assign in_ready = ~flushing;
  assign accept   = in_valid & ~flushing;

  always_comb begin
    step_en   = accept | flushing;
    step_clr  = accept & in_sof;
    step_data = flushing ? last_q : in_data;
    cur_t     = step_clr ? '0 : t_cnt;
    cur_ph    = step_clr ? '0 : ph;
    keep      = step_en && (cur_t == TW'(DELAY)) && (cur_ph == '0);
    // last kept result of the frame: no further kept slot fits in the tail
    keep_last = keep && flushing && (int'(pad_cnt) >= DELAY - DECIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flushing <= 1'b0;
      pad_cnt  <= '0;
      t_cnt    <= '0;
      ph       <= '0;
      last_q   <= '0;
    end else begin
      if (step_en) begin
        if (cur_t != TW'(DELAY)) begin
          t_cnt <= cur_t + 1'b1;
          ph    <= '0;
        end else begin
          t_cnt <= cur_t;
          ph    <= (cur_ph == PW'(DECIM - 1)) ? '0 : cur_ph + 1'b1;
        end
      end
      if (accept) last_q <= in_data;
      if (accept && in_eof) begin
        flushing <= 1'b1;
        pad_cnt  <= '0;
      end else if (flushing) begin
        if (pad_cnt == TW'(DELAY - 1)) flushing <= 1'b0;
        pad_cnt <= pad_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dcfd_tapline.sv
module dcfd_tapline #(
  parameter int DW   = 16,
  parameter int TAPS = 31
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_en,
  input  logic                 step_clr,
  input  logic signed [DW-1:0] step_data,
  output logic signed [DW-1:0] win [TAPS]
);
  logic signed [DW-1:0] line_q [TAPS-1];

  // win is the window after this step: newest at index 0
  assign win[0] = step_data;
  for (genvar i = 1; i < TAPS; i++) begin : g_win
    assign win[i] = step_clr ? '0 : line_q[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS - 1; i++) line_q[i] <= '0;
    end else if (step_en) begin
      for (int i = 0; i < TAPS - 1; i++) line_q[i] <= win[i];
    end
  end

endmodule

// File: rtl/dcfd_mac.sv
module dcfd_mac #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int TAPS  = 31,
  parameter int LANES = 4,
  parameter int FRAC  = 15,
  parameter logic signed [CW-1:0] COEF [TAPS] = '{default: '0}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 load_last,
  input  logic signed [DW-1:0] win [TAPS],
  output logic                 out_valid,
  output logic                 out_eof,
  output logic signed [DW-1:0] out_data
);
  localparam int NCYC = (TAPS + LANES - 1) / LANES;
  localparam int PADN = NCYC * LANES;
  localparam int SW   = (NCYC > 2) ? $clog2(NCYC) : 1;
  localparam int PW   = DW + CW;
  localparam int ACCW = DW + CW + $clog2(TAPS);
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((1 << (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -ACCW'(1 << (DW - 1));
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1 << (FRAC - 1));

  logic signed [DW-1:0]   snap_q [PADN];
  logic                   busy_q;
  logic                   last_q;
  logic [SW-1:0]          step_q;
  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] part;
  logic signed [ACCW-1:0] acc_nxt;
  logic signed [PW-1:0]   prod [LANES];

  function automatic logic signed [CW-1:0] coef_at(input int idx);
    if (idx < TAPS) return COEF[idx];
    return '0;
  endfunction

  function automatic logic signed [DW-1:0] round_sat(input logic signed [ACCW-1:0] a);
    logic signed [ACCW-1:0] b;
    logic signed [ACCW-1:0] q;
    b = a + HALF - {{(ACCW-1){1'b0}}, a[ACCW-1]};
    q = b >>> FRAC;
    if (q > MAXV) return MAXV[DW-1:0];
    if (q < MINV) return MINV[DW-1:0];
    return q[DW-1:0];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [CW-1:0] c_l;
    assign c_l     = coef_at(int'(step_q) * LANES + l);
    assign prod[l] = PW'(snap_q[l]) * PW'(c_l);
  end

  always_comb begin
    part = '0;
    for (int l = 0; l < LANES; l++) part = part + ACCW'(prod[l]);
    acc_nxt = acc_q + part;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PADN; i++) snap_q[i] <= '0;
      busy_q    <= 1'b0;
      last_q    <= 1'b0;
      step_q    <= '0;
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      if (load) begin
        for (int i = 0; i < PADN; i++) snap_q[i] <= '0;
        for (int i = 0; i < TAPS; i++) snap_q[i] <= win[i];
        busy_q <= 1'b1;
        last_q <= load_last;
        step_q <= '0;
        acc_q  <= '0;
      end else if (busy_q) begin
        for (int i = 0; i < PADN - LANES; i++) snap_q[i] <= snap_q[i+LANES];
        for (int i = PADN - LANES; i < PADN; i++) snap_q[i] <= '0;
        acc_q  <= acc_nxt;
        step_q <= step_q + 1'b1;
        if (step_q == SW'(NCYC - 1)) begin
          busy_q    <= 1'b0;
          out_valid <= 1'b1;
          out_eof   <= last_q;
          out_data  <= round_sat(acc_nxt);
        end
      end
    end
  end

endmodule

// File: rtl/dcfd_decimator.sv
module dcfd_decimator
  import dcfd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int TAPS  = DCFD_TAPS,
  parameter int DECIM = 10,
  parameter int FRAC  = 15,
  parameter logic signed [CW-1:0] COEF [TAPS] = DCFD_COEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic signed [DW-1:0] in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 out_eof,
  output logic signed [DW-1:0] out_data
);
  localparam int DELAY = (TAPS - 1) / 2;
  localparam int LANES = ceil_div(TAPS, DECIM);

  logic                 step_en;
  logic                 step_clr;
  logic signed [DW-1:0] step_data;
  logic                 keep;
  logic                 keep_last;
  logic signed [DW-1:0] win [TAPS];

  dcfd_seq #(.DW(DW), .DECIM(DECIM), .DELAY(DELAY)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .step_en   (step_en),
    .step_clr  (step_clr),
    .step_data (step_data),
    .keep      (keep),
    .keep_last (keep_last)
  );

  dcfd_tapline #(.DW(DW), .TAPS(TAPS)) u_line (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .step_clr  (step_clr),
    .step_data (step_data),
    .win       (win)
  );

  dcfd_mac #(
    .DW(DW), .CW(CW), .TAPS(TAPS), .LANES(LANES), .FRAC(FRAC), .COEF(COEF)
  ) u_mac (
    .clk       (clk),
    .rst       (rst),
    .load      (keep),
    .load_last (keep_last),
    .win       (win),
    .out_valid (out_valid),
    .out_eof   (out_eof),
    .out_data  (out_data)
  );

endmodule

// File: rtl/dcfd_checker.sv
module dcfd_checker #(
  parameter int DECIM = 10,
  parameter int DELAY = 15
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_eof,
  input logic in_ready,
  input logic out_valid,
  input logic out_eof
);
  localparam int GW = $clog2(DECIM + 1);
  localparam int LW = $clog2(DELAY + 2);

  logic [GW-1:0] gap_q;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GW'(DECIM);
      low_q <= '0;
    end else begin
      if (out_valid) gap_q <= '0;
      else if (gap_q != GW'(DECIM)) gap_q <= gap_q + 1'b1;
      if (in_ready) low_q <= '0;
      else if (low_q != LW'(DELAY + 1)) low_q <= low_q + 1'b1;
    end
  end

  AST_OUT_SPACING: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (gap_q >= GW'(DECIM - 1)));                           // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);                                          // R8
  AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid);                                             // R8
  AST_TAIL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eof) |=> !in_ready);                    // R9
  AST_TAIL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (low_q < LW'(DELAY)));                                // R9
  AST_STREAM_READY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_eof) |=> in_ready);                    // R10

endmodule

bind dcfd_decimator dcfd_checker #(.DECIM(DECIM), .DELAY(DELAY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_eof    (in_eof),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_eof   (out_eof)
);

// File: tb/tb_dcfd_decimator.sv
module tb_dcfd_decimator;
  import dcfd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DECIM = 10;
  localparam int DELAY = 15;
  localparam int TAPS  = DCFD_TAPS;
  localparam int MAXN  = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid, out_eof;
  logic signed [15:0] out_data;

  dcfd_decimator dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_eof(out_eof), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit poke_en = 1'b0;
  int fx [MAXN];
  int fn;
  int exp_d[$];
  bit exp_e[$];
  int got_d[$];
  bit got_e[$];

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      got_d.push_back(int'(out_data));
      got_e.push_back(out_eof);
    end
  end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int model_out(input int n);
    longint s = 0;
    longint r;
    for (int k = 0; k < TAPS; k++) begin
      int m = n - k;
      int xv = (m < 0) ? 0 : ((m < fn) ? fx[m] : fx[fn-1]);
      s += longint'(DCFD_COEF[k]) * longint'(xv);
    end
    if (s >= 0) r = (s + 16384) / 32768;
    else        r = -((-s + 16384) / 32768);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic add_expected();
    for (int j = 0; DELAY + DECIM*j <= fn + DELAY - 1; j++) begin
      exp_d.push_back(model_out(DELAY + DECIM*j));
      exp_e.push_back(DELAY + DECIM*(j+1) > fn + DELAY - 1);
    end
  endtask

  task automatic junk();
    in_valid = poke_en;
    in_sof   = poke_en;
    in_eof   = poke_en & $urandom_range(0, 1);
    in_data  = 16'($urandom);
  endtask

  task automatic put(input int d, input bit s, input bit e, input bit gap, output int waited);
    waited = 0;
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (in_ready) break;
      waited++;
      junk();
    end
    in_valid = 1'b1;
    in_sof   = s;
    in_eof   = e;
    in_data  = 16'(d);
  endtask

  task automatic run_frame(input bit gaps);
    int w;
    int stall = 0;
    int lowc = 0;
    add_expected();
    for (int i = 0; i < fn; i++) begin
      put(fx[i], i == 0, i == fn - 1, gaps && ($urandom_range(0, 3) == 0), w);
      if (i > 0) stall += w;
    end
    forever begin
      @(negedge clk);
      if (in_ready) break;
      lowc++;
      junk();
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    check("R9 tail ready-low cycles", lowc, DELAY);
    if (!gaps) check("R10 no stall inside frame", stall, 0);
  endtask

  task automatic finish_batch(input string tag);
    int n;
    repeat (40) @(negedge clk);
    check({"R2 output count ", tag}, got_d.size(), exp_d.size());
    n = (got_d.size() < exp_d.size()) ? got_d.size() : exp_d.size();
    for (int i = 0; i < n; i++) begin
      check({"R3 value ", tag}, got_d[i], exp_d[i]);
      check({"R8 eof flag ", tag}, int'(got_e[i]), int'(exp_e[i]));
    end
  endtask

  task automatic clear_q();
    exp_d.delete(); exp_e.delete(); got_d.delete(); got_e.delete();
  endtask

  task automatic zero_frame(input int n);
    fn = n;
    for (int i = 0; i < MAXN; i++) fx[i] = 0;
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_eof after reset", int'(out_eof), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // R3 impulse: first output is centre tap times x[0]
    zero_frame(40); fx[0] = 20000;
    run_frame(1'b0); finish_batch("impulse");
    if (got_d.size() > 0)
      check("R3 first output centre tap", got_d[0],
            (int'(DCFD_COEF[DELAY]) * 20000 + 16384) / 32768);
    clear_q();

    // R4 step: tail pads repeat last sample, last output fully settled
    zero_frame(50);
    for (int i = 0; i < 50; i++) fx[i] = 10000;
    run_frame(1'b1); finish_batch("step");
    if (got_d.size() == 5) check("R4 settled tail output", got_d[4], 10000);
    clear_q();

    // R6 exact halves: 110*2 - 12*(-1347) = +16384 -> +1, negated -> -1
    zero_frame(20); fx[10] = 2; fx[11] = -1347;
    run_frame(1'b0); finish_batch("round+");
    if (got_d.size() > 0) check("R6 +half rounds away", got_d[0], 1);
    clear_q();
    zero_frame(20); fx[10] = -2; fx[11] = 1347;
    run_frame(1'b0); finish_batch("round-");
    if (got_d.size() > 0) check("R6 -half rounds away", got_d[0], -1);
    clear_q();

    // R7 saturation: window at n=25 matches coefficient signs
    zero_frame(30);
    for (int m = 0; m < 26; m++) fx[m] = (DCFD_COEF[25-m] < 0) ? -32768 : 32767;
    run_frame(1'b0); finish_batch("sat+");
    if (got_d.size() > 1) check("R7 positive clip", got_d[1], 32767);
    clear_q();
    zero_frame(30);
    for (int m = 0; m < 26; m++) fx[m] = (DCFD_COEF[25-m] < 0) ? 32767 : -32768;
    run_frame(1'b0); finish_batch("sat-");
    if (got_d.size() > 1) check("R7 negative clip", got_d[1], -32768);
    clear_q();

    // R5 back-to-back frames: loud frame then a small impulse
    zero_frame(30);
    for (int i = 0; i < 30; i++) fx[i] = 30000;
    run_frame(1'b0);
    zero_frame(20); fx[0] = 100;
    run_frame(1'b0);
    finish_batch("back-to-back");
    if (got_d.size() > 3) check("R5 history cleared at sof", got_d[3], 9);
    clear_q();

    // single-sample and ten-sample frames
    zero_frame(1); fx[0] = -5000;
    run_frame(1'b0); finish_batch("n=1"); clear_q();
    zero_frame(10);
    for (int i = 0; i < 10; i++) fx[i] = i * 1000 - 4000;
    run_frame(1'b0); finish_batch("n=10"); clear_q();

    // R9 random frames, junk driven while in_ready is low
    poke_en = 1'b1;
    for (int f = 0; f < 10; f++) begin
      zero_frame($urandom_range(1, 120));
      for (int i = 0; i < fn; i++) fx[i] = int'($urandom_range(0, 65535)) - 32768;
      run_frame(f[0]);
      finish_batch("random");
      clear_q();
    end
    poke_en = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule